// File: doc/BRIEF.md
# Permission-Checking Address Translation Unit

This block sits on one memory port of a 32-bit core whose instruction and data address spaces are kept apart. Each request carries a virtual address, an access kind (fetch, load or store), the privilege level, an 8-bit address-space ID and two capability bits. The unit answers with a physical address or a fault cause. A small fully associative TLB caches page permissions. The lookup key is the 20-bit virtual page number, the address-space ID and the port side (fetch or data).

On a miss, a fixed region walker builds the entry. It does not read page tables from memory. It recognises three regions, instruction ROM, data RAM and the MMIO window, each with constant permission flags, and maps every page to itself. The walker refuses to build an entry for a fetch from RAM or for a data access to ROM. Those two cases are reported as Harvard violations. A user-mode access needs the page's user flag and also a capability bit. Capability bit 0 covers RAM and capability bit 1 covers MMIO.

Two instances are expected per core: one for fetches and one for data. The data instance has a TLB twice as deep.

Top module: `vm_perm_unit`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low while a response is pending. The response appears with `rsp_valid` in the cycle after acceptance, for both hit and miss. It stays unchanged until a cycle in which `rsp_ready` is high.
- R2: A granted access returns `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` equal to the request address, so the page number maps to itself and the low 12 offset bits pass through. A denied access returns `rsp_fault`=1 and `rsp_paddr`=0.
- R3: A fetch (`req_kind`=0) inside RAM, or a load (1) or store (2) inside ROM, faults with cause 0x0A. This holds even when the page is already cached, and it takes priority over every other cause.
- R4: A supervisor fetch from ROM is granted. A user-mode fetch from ROM faults with cause 0x01, because ROM pages carry no user flag. Any fetch from MMIO faults with cause 0x01.
- R5: A supervisor load or store to RAM is granted. A user-mode one is granted only when capability bit 0 is set. Otherwise it faults with cause 0x05 (load) or 0x07 (store).
- R6: A supervisor load or store to MMIO is granted. A user-mode one needs capability bit 1, and capability bit 0 has no effect there. Denials report 0x05 or 0x07.
- R7: An address outside all three regions faults with 0x01, 0x05 or 0x07 according to the access kind. This holds even when its page is already cached.
- R8: A region whose flags have both W (0x04) and X (0x08) set is refused for every access kind. Flags are V=0x01, R=0x02, W=0x04, X=0x08, U=0x10, G=0x20, A=0x40, D=0x80.
- R9: `rsp_hit` is 1 when the page, address-space ID and side were already cached. The first access to a key misses and a repeat hits. A different address-space ID or a different side misses.
- R10: A `flush` pulse invalidates every entry and restarts the replacement pointer, so the next access to any key misses.
- R11: Entries are replaced in round-robin order, starting at slot 0 after reset or flush.
- R12: Only a miss whose walk yields a valid entry fills a slot. A Harvard violation or an out-of-region miss leaves the entries and the replacement pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all TLB entries (instruction-fence pulse) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store (3 handled as load) |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| req_asid | input | 8 | Address-space ID |
| req_caps | input | 2 | Bit 0 grants user RAM, bit 1 grants user MMIO |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 4 | Fault cause, 0 when granted |
| rsp_hit | output | 1 | Lookup found a cached entry |

## Verification
The bench sweeps every access kind, privilege and capability pattern across addresses at both edges of each region and just past them, and compares the result with a cause computed from the region rules. Several corner cases are targeted. A design that trusted a cached page over the region bounds would grant 0x1400 after 0x1000 was cached, or report an access fault instead of a Harvard violation for ROM data in page 0. A replacement pointer that advanced on a failed walk would evict the wrong slot in the round-robin sequence. A second instance with RAM marked both writable and executable must deny all RAM accesses, which catches a missing W^X test.

// File: rtl/vm_perm_pkg.sv
package vm_perm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ROM  = 2'd1,
        RG_RAM  = 2'd2,
        RG_MMIO = 2'd3
    } region_e;

    localparam int FB_V = 0;
    localparam int FB_R = 1;
    localparam int FB_W = 2;
    localparam int FB_X = 3;
    localparam int FB_U = 4;
    localparam int FB_A = 6;
    localparam int FB_D = 7;

    localparam logic [3:0] CZ_NONE    = 4'h0;
    localparam logic [3:0] CZ_FETCH   = 4'h1;
    localparam logic [3:0] CZ_LOAD    = 4'h5;
    localparam logic [3:0] CZ_STORE   = 4'h7;
    localparam logic [3:0] CZ_HARVARD = 4'hA;

    typedef struct packed {
        logic        side;
        logic [7:0]  asid;
        logic [19:0] vpn;
    } tlb_key_t;

    function automatic logic in_span(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
        return (a - lo) <= (hi - lo);
    endfunction

    function automatic logic [3:0] denial_code(acc_e k);
        case (k)
            ACC_FETCH: return CZ_FETCH;
            ACC_STORE: return CZ_STORE;
            default:   return CZ_LOAD;
        endcase
    endfunction

    function automatic logic flags_grant(logic [7:0] f, acc_e k, logic user, logic cap_ok);
        logic ok;
        case (k)
            ACC_FETCH: ok = f[FB_X] && !f[FB_W];
            ACC_STORE: ok = f[FB_W] && f[FB_D] && !f[FB_X];
            default:   ok = f[FB_R] && !f[FB_X];
        endcase
        ok = ok && f[FB_V] && f[FB_A] && !(f[FB_W] && f[FB_X]);
        if (user) begin
            ok = ok && f[FB_U] && cap_ok;
        end
        return ok;
    endfunction

endpackage

// File: rtl/vm_region_walker.sv
module vm_region_walker
    import vm_perm_pkg::*;
#(
    parameter logic [31:0] ROM_LO     = 32'h0000_0000,
    parameter logic [31:0] ROM_HI     = 32'h0000_03FF,
    parameter logic [31:0] RAM_LO     = 32'h0000_0400,
    parameter logic [31:0] RAM_HI     = 32'h0000_13FF,
    parameter logic [31:0] MMIO_LO    = 32'hFFFF_0000,
    parameter logic [31:0] MMIO_HI    = 32'hFFFF_00FF,
    parameter logic [7:0]  ROM_FLAGS  = 8'h49,
    parameter logic [7:0]  RAM_FLAGS  = 8'hD7,
    parameter logic [7:0]  MMIO_FLAGS = 8'hD7
) (
    input  logic [31:0] vaddr,
    input  acc_e        kind,
    output region_e     region,
    output logic        harvard,
    output logic        walk_ok,
    output logic [7:0]  walk_flags
);

    logic is_fetch;
    assign is_fetch = (kind == ACC_FETCH);

    always_comb begin
        if (in_span(vaddr, ROM_LO, ROM_HI)) begin
            region = RG_ROM;
        end else if (in_span(vaddr, RAM_LO, RAM_HI)) begin
            region = RG_RAM;
        end else if (in_span(vaddr, MMIO_LO, MMIO_HI)) begin
            region = RG_MMIO;
        end else begin
            region = RG_NONE;
        end
    end

    assign harvard = (is_fetch && region == RG_RAM) || (!is_fetch && region == RG_ROM);
    assign walk_ok = (region != RG_NONE) && !harvard;

    always_comb begin
        case (region)
            RG_ROM:  walk_flags = ROM_FLAGS;
            RG_RAM:  walk_flags = RAM_FLAGS;
            RG_MMIO: walk_flags = MMIO_FLAGS;
            default: walk_flags = 8'h00;
        endcase
        if (!walk_ok) begin
            walk_flags = 8'h00;
        end
    end

endmodule

// File: rtl/vm_tlb_array.sv
module vm_tlb_array
    import vm_perm_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  tlb_key_t   lk_key,
    output logic       lk_hit,
    output logic [7:0] lk_flags,
    input  logic       fill_en,
    input  tlb_key_t   fill_key,
    input  logic [7:0] fill_flags
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    tlb_key_t           keys [ENTRIES];
    logic [7:0]         flg  [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   ptr;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (keys[g] == lk_key);
    end

    assign lk_hit = |match;

    always_comb begin
        lk_flags = 8'h00;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_flags = lk_flags | flg[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld <= '0;
            ptr <= '0;
        end else if (fill_en) begin
            vld[ptr] <= 1'b1;
            ptr      <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            keys[ptr] <= fill_key;
            flg[ptr]  <= fill_flags;
        end
    end

endmodule

// File: rtl/vm_perm_check.sv
module vm_perm_check
    import vm_perm_pkg::*;
(
    input  acc_e       kind,
    input  logic       user,
    input  logic [1:0] caps,
    input  region_e    region,
    input  logic       harvard,
    input  logic       hit,
    input  logic [7:0] hit_flags,
    input  logic       walk_ok,
    input  logic [7:0] walk_flags,
    output logic       fault,
    output logic [3:0] cause
);

    logic [7:0] eff_flags;
    logic       cap_ok;
    logic       have_entry;

    assign eff_flags  = hit ? hit_flags : walk_flags;
    assign have_entry = hit || walk_ok;
    assign cap_ok     = (region == RG_MMIO) ? caps[1] : caps[0];

    always_comb begin
        if (harvard) begin
            cause = CZ_HARVARD;
        end else if (region == RG_NONE || !have_entry) begin
            cause = denial_code(kind);
        end else if (!flags_grant(eff_flags, kind, user, cap_ok)) begin
            cause = denial_code(kind);
        end else begin
            cause = CZ_NONE;
        end
    end

    assign fault = (cause != CZ_NONE);

endmodule

// File: rtl/vm_perm_unit.sv
module vm_perm_unit
    import vm_perm_pkg::*;
#(
    parameter int          ENTRIES    = 32,
    parameter logic [31:0] ROM_LO     = 32'h0000_0000,
    parameter logic [31:0] ROM_HI     = 32'h0000_03FF,
    parameter logic [31:0] RAM_LO     = 32'h0000_0400,
    parameter logic [31:0] RAM_HI     = 32'h0000_13FF,
    parameter logic [31:0] MMIO_LO    = 32'hFFFF_0000,
    parameter logic [31:0] MMIO_HI    = 32'hFFFF_00FF,
    parameter logic [7:0]  ROM_FLAGS  = 8'h49,
    parameter logic [7:0]  RAM_FLAGS  = 8'hD7,
    parameter logic [7:0]  MMIO_FLAGS = 8'hD7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        req_user,
    input  logic [7:0]  req_asid,
    input  logic [1:0]  req_caps,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [3:0]  rsp_cause,
    output logic        rsp_hit
);

    acc_e       kind;
    tlb_key_t   key;
    region_e    region;
    logic       harvard;
    logic       walk_ok;
    logic [7:0] walk_flags;
    logic       hit;
    logic [7:0] hit_flags;
    logic       fault;
    logic [3:0] cause;
    logic       accept;
    logic       fill_en;

    assign kind     = acc_e'(req_kind);
    assign key.side = (kind == ACC_FETCH);
    assign key.asid = req_asid;
    assign key.vpn  = req_vaddr[31:12];

    assign req_ready = !rsp_valid;
    assign accept    = req_valid && req_ready;
    assign fill_en   = accept && !hit && walk_ok;

    vm_region_walker #(
        .ROM_LO(ROM_LO), .ROM_HI(ROM_HI),
        .RAM_LO(RAM_LO), .RAM_HI(RAM_HI),
        .MMIO_LO(MMIO_LO), .MMIO_HI(MMIO_HI),
        .ROM_FLAGS(ROM_FLAGS), .RAM_FLAGS(RAM_FLAGS), .MMIO_FLAGS(MMIO_FLAGS)
    ) u_walk (
        .vaddr      (req_vaddr),
        .kind       (kind),
        .region     (region),
        .harvard    (harvard),
        .walk_ok    (walk_ok),
        .walk_flags (walk_flags)
    );

    vm_tlb_array #(
        .ENTRIES(ENTRIES)
    ) u_tlb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .lk_key     (key),
        .lk_hit     (hit),
        .lk_flags   (hit_flags),
        .fill_en    (fill_en),
        .fill_key   (key),
        .fill_flags (walk_flags)
    );

    vm_perm_check u_chk_perm (
        .kind       (kind),
        .user       (req_user),
        .caps       (req_caps),
        .region     (region),
        .harvard    (harvard),
        .hit        (hit),
        .hit_flags  (hit_flags),
        .walk_ok    (walk_ok),
        .walk_flags (walk_flags),
        .fault      (fault),
        .cause      (cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CZ_NONE;
            rsp_hit   <= 1'b0;
        end else if (accept) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= fault ? 32'h0 : {req_vaddr[31:12], req_vaddr[11:0]};
            rsp_fault <= fault;
            rsp_cause <= cause;
            rsp_hit   <= hit;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/vm_perm_unit_chk.sv
module vm_perm_unit_chk #(
    parameter logic [31:0] RAM_LO = 32'h0000_0400,
    parameter logic [31:0] RAM_HI = 32'h0000_13FF
) (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [3:0]  rsp_cause,
    input logic        rsp_hit
);

    logic flush_q;
    logic acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) flush_q <= 1'b0;
        else     flush_q <= flush;
    end

    assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_answer_R1: assert property (@(posedge clk) disable iff (rst)
        acc |=> rsp_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
            $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_hit)));

    assert_identity_R2: assert property (@(posedge clk) disable iff (rst)
        acc |=> (rsp_fault || rsp_paddr == $past(req_vaddr)));

    assert_clean_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault ? (rsp_paddr == 32'h0 && rsp_cause != 4'h0)
                                 : (rsp_cause == 4'h0)));

    assert_harvard_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind == 2'd0 && (req_vaddr - RAM_LO) <= (RAM_HI - RAM_LO))
            |=> (rsp_fault && rsp_cause == 4'hA));

    assert_flush_R10: assert property (@(posedge clk) disable iff (rst)
        (flush_q && acc) |=> !rsp_hit);

endmodule

bind vm_perm_unit vm_perm_unit_chk #(
    .RAM_LO(RAM_LO),
    .RAM_HI(RAM_HI)
) u_prop (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_kind  (req_kind),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_hit   (rsp_hit)
);

// File: tb/vm_perm_unit_test.sv
`timescale 1ns/1ps
module vm_perm_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [7:0]  req_asid = '0;
    logic [1:0]  req_caps = '0;
    logic        rsp_ready = 1'b1;

    logic        req_ready, rsp_valid, rsp_fault, rsp_hit;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_cause;
    logic        wx_ready, wx_valid, wx_fault, wx_hit;
    logic [31:0] wx_paddr;
    logic [3:0]  wx_cause;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    vm_perm_unit #(.ENTRIES(4)) uut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .req_asid(req_asid),
        .req_caps(req_caps), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_hit(rsp_hit)
    );

    vm_perm_unit #(.ENTRIES(4), .RAM_FLAGS(8'hDF)) uut_wx (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_ready(wx_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .req_asid(req_asid),
        .req_caps(req_caps), .rsp_valid(wx_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(wx_paddr), .rsp_fault(wx_fault), .rsp_cause(wx_cause),
        .rsp_hit(wx_hit)
    );

    task automatic summary_and_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog: run did not finish (got %0d cycles, expected fewer)", cyc);
            summary_and_end();
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] deny(input logic [1:0] k);
        return (k == 2'd0) ? 4'h1 : (k == 2'd2) ? 4'h7 : 4'h5;
    endfunction

    function automatic logic [3:0] expect_cause(input logic [31:0] a, input logic [1:0] k,
                                                input logic u, input logic [1:0] c, input logic wx);
        logic rom, ram, mmio;
        rom  = a <= 32'h3FF;
        ram  = a >= 32'h400 && a <= 32'h13FF;
        mmio = a >= 32'hFFFF_0000 && a <= 32'hFFFF_00FF;
        if ((k == 2'd0 && ram) || (k != 2'd0 && rom)) return 4'hA;
        if (!(rom || ram || mmio)) return deny(k);
        if (k == 2'd0) begin
            if (mmio || u) return 4'h1;
            return 4'h0;
        end
        if (ram && wx) return deny(k);
        if (u && ram && !c[0]) return deny(k);
        if (u && mmio && !c[1]) return deny(k);
        return 4'h0;
    endfunction

    task automatic do_req(input logic [31:0] a, input logic [1:0] k, input logic u,
                          input logic [7:0] asid, input logic [1:0] c);
        @(negedge clk);
        req_vaddr = a; req_kind = k; req_user = u; req_asid = asid; req_caps = c;
        req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic load_hit(input logic [7:0] asid, input logic exp_hit, input string tag);
        do_req(32'h0000_1000, 2'd1, 1'b0, asid, 2'b00);
        check(tag, {63'h0, rsp_hit}, {63'h0, exp_hit});
    endtask

    initial begin
        logic [31:0] addrs [12];
        logic [3:0]  ec;
        addrs = '{32'h0, 32'h3FC, 32'h400, 32'h0ABC, 32'h13FC, 32'h1400, 32'h2008,
                  32'hFFFF_0000, 32'hFFFF_00FC, 32'hFFFF_0100, 32'h8000_0010, 32'h0000_0123};
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
        check("R1 reset req_ready", {63'h0, req_ready}, 64'h1);
        rst = 1'b0;

        // R2 R3 R4 R5 R6 R7 R8: sweep of region, kind, privilege and capability
        for (int ai = 0; ai < 12; ai++) begin
            for (int k = 0; k < 3; k++) begin
                for (int u = 0; u < 2; u++) begin
                    for (int c = 0; c < 4; c++) begin
                        do_req(addrs[ai], 2'(k), 1'(u), 8'h00, 2'(c));
                        ec = expect_cause(addrs[ai], 2'(k), 1'(u), 2'(c), 1'b0);
                        check("R2/R3/R4/R5/R6/R7 sweep",
                              {27'h0, rsp_valid, rsp_fault, rsp_cause, rsp_paddr},
                              {27'h0, 1'b1, ec != 4'h0, ec, (ec != 4'h0) ? 32'h0 : addrs[ai]});
                        ec = expect_cause(addrs[ai], 2'(k), 1'(u), 2'(c), 1'b1);
                        check("R8 wx sweep", {27'h0, wx_valid, wx_fault, wx_cause, 32'h0},
                              {27'h0, 1'b1, ec != 4'h0, ec, 32'h0});
                    end
                end
            end
        end

        // R3 on a cached page: data page 0 holds RAM flags, ROM part still Harvard
        do_flush();
        do_req(32'h0000_0400, 2'd1, 1'b0, 8'h11, 2'b00);
        do_req(32'h0000_0100, 2'd1, 1'b0, 8'h11, 2'b00);
        check("R3 cached harvard", {58'h0, rsp_hit, rsp_fault, rsp_cause}, {58'h0, 1'b1, 1'b1, 4'hA});
        // R7 on a cached page: 0x1400 shares page 1 with RAM
        do_req(32'h0000_1000, 2'd2, 1'b0, 8'h11, 2'b00);
        do_req(32'h0000_1400, 2'd2, 1'b0, 8'h11, 2'b00);
        check("R7 cached outside", {58'h0, rsp_hit, rsp_fault, rsp_cause}, {58'h0, 1'b1, 1'b1, 4'h7});

        // R1 hold while rsp_ready is low
        @(negedge clk);
        req_vaddr = 32'h0000_0808; req_kind = 2'd1; req_user = 1'b0; req_asid = 8'h11;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 3; w++) begin
            check("R1 hold valid/ready/paddr", {30'h0, rsp_valid, req_ready, rsp_paddr},
                  {30'h0, 1'b1, 1'b0, 32'h0000_0808});
            @(negedge clk);
        end
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        check("R1 release", {63'h0, rsp_valid}, 64'h0);

        // R9 key = page + asid + side
        do_flush();
        load_hit(8'h05, 1'b0, "R9 first miss");
        load_hit(8'h05, 1'b1, "R9 repeat hit");
        load_hit(8'h06, 1'b0, "R9 other asid miss");
        do_req(32'h0000_0000, 2'd0, 1'b0, 8'h05, 2'b00);
        check("R9 fetch side miss", {63'h0, rsp_hit}, 64'h0);
        do_req(32'h0000_0400, 2'd1, 1'b0, 8'h05, 2'b00);
        check("R9 data side miss", {63'h0, rsp_hit}, 64'h0);
        do_req(32'h0000_0004, 2'd0, 1'b0, 8'h05, 2'b00);
        check("R9 fetch side hit", {63'h0, rsp_hit}, 64'h1);

        // R10 flush
        do_flush();
        load_hit(8'h05, 1'b0, "R10 miss after flush");

        // R11 round robin
        do_flush();
        for (int a = 0; a < 4; a++) load_hit(8'(a), 1'b0, "R11 fill");
        load_hit(8'h04, 1'b0, "R11 evict slot0");
        load_hit(8'h01, 1'b1, "R11 slot1 kept");
        load_hit(8'h00, 1'b0, "R11 slot0 evicted");
        load_hit(8'h01, 1'b0, "R11 slot1 evicted next");
        load_hit(8'h03, 1'b1, "R11 slot3 kept");

        // R12 failed walks do not fill
        do_flush();
        for (int a = 0; a < 3; a++) load_hit(8'(a), 1'b0, "R12 fill");
        do_req(32'h0000_1000, 2'd0, 1'b0, 8'h09, 2'b00);
        check("R12 harvard no fill", {59'h0, rsp_fault, rsp_cause}, {59'h0, 1'b1, 4'hA});
        do_req(32'h0000_2000, 2'd1, 1'b0, 8'h09, 2'b00);
        check("R12 outside no fill", {59'h0, rsp_fault, rsp_cause}, {59'h0, 1'b1, 4'h5});
        do_req(32'h0000_1000, 2'd0, 1'b0, 8'h09, 2'b00);
        check("R12 harvard still miss", {63'h0, rsp_hit}, 64'h0);
        load_hit(8'h03, 1'b0, "R12 slot3 fill");
        load_hit(8'h04, 1'b0, "R12 slot0 fill");
        load_hit(8'h01, 1'b1, "R12 slot1 kept");
        load_hit(8'h02, 1'b1, "R12 slot2 kept");
        load_hit(8'h00, 1'b0, "R12 slot0 replaced");

        summary_and_end();
    end

endmodule